// File: doc/BRIEF.md
# Multi-Lane Adler-32 Checksum Engine

This block computes the Adler-32 checksum of one message at a time. Bytes arrive `LANES` per beat on a valid/ready input. Each lane keeps its own pair of running sums, modulo 65521, and the lanes do not interact while data streams in. Within a beat, lane 0 holds the earliest byte.

A message whose length is not a multiple of `LANES` is aligned by treating its first beat as zero-padded at the front. Leading zeros change neither sum, so this padding is harmless.

After the beat flagged as last, a merge sequencer visits the lanes one per cycle. It folds their sums into the standard 32-bit checksum, using the unpadded message length. It then raises a one-cycle done strobe with the result on the checksum port. Input is refused while the merge runs, and the next message may start on the cycle the strobe appears.

Top module: `adl_engine`

## Requirements
- R1: Both 16-bit halves of the reported checksum are always below 65521.
- R2: For every byte it receives, a lane first adds the byte into its A sum, then adds the new A sum into its B sum, each reduced modulo 65521. Every lane register stays below 65521 at all times, including on long runs of 0xFF bytes.
- R3: A beat carries `in_count` valid bytes, placed in the highest-numbered lanes `LANES-in_count` to `LANES-1`. Lanes below that are read as zero, whatever is on `in_data`. Only the first beat of a message may have `in_count < LANES`.
- R4: The low half of the result equals 1 plus the sum of all message bytes, modulo 65521.
- R5: The high half of the result equals the true message length plus the sum over message bytes of byte × (bytes from it to the end, counting itself), modulo 65521. Padding bytes do not count toward the length.
- R6: The result is presented as `cks_o = {B[15:0], A[15:0]}`, and it is valid while `done_o` is high.
- R7: After the edge that accepts a beat with `in_last` high:
  - `in_ready` is low for exactly `LANES` cycles.
  - `done_o` is then high for exactly one cycle, together with `in_ready` high.
  - After reset, `in_ready` is high, `done_o` is low and `cks_o` is zero.
- R8: A message consisting of a single last beat with `in_count = 0` yields `0x00000001`.
- R9: Consecutive messages are independent: all lane sums and the length are cleared when a result is produced.
- R10: Cycles with `in_valid` low between beats have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A beat is offered |
| in_ready | output | 1 | Engine accepts a beat (low while merging) |
| in_data | input | 8*LANES | Beat bytes, lane l at bits [8l+7:8l] |
| in_count | input | $clog2(LANES+1) | Valid bytes in this beat, aligned to the top lanes |
| in_last | input | 1 | This beat ends the message |
| done_o | output | 1 | One-cycle strobe: result valid |
| cks_o | output | 32 | Checksum {B, A} |

## Verification
The bench builds the engine with `LANES = 4`. With that value, a sweep of every message length from 0 to 40 covers all four front-padding amounts, many times over. It also covers single-beat and empty messages, and both with and without idle gaps between beats. Messages of 700 and 1024 bytes push both sums through many modulo wraps. In particular, all-0xFF data makes the A sum wrap after 257 bytes. The merge weights for every lane index up to 3 are exercised against a plain serial reference checksum computed in the bench.

// File: rtl/adl_pkg.sv
// Shared constants and modulo helpers for the multi-lane Adler-32 engine.
// Assumes all operands handed to the helpers are already below the modulus
// unless stated otherwise.
package adl_pkg;

    localparam int unsigned ADL_MOD = 65521;

    typedef logic [15:0] sum16_t;

    // Add two reduced values and reduce the result; valid while a+b < 2*ADL_MOD.
    function automatic sum16_t mod_add(input sum16_t x, input sum16_t y);
        logic [16:0] s;
        s = 17'(x) + 17'(y);
        if (s >= 17'(ADL_MOD)) s = s - 17'(ADL_MOD);
        return s[15:0];
    endfunction

    // Reduce any 32-bit value modulo 65521 using 2^16 = 15 (mod 65521).
    function automatic sum16_t fold32(input logic [31:0] x);
        logic [20:0] s1;
        logic [16:0] s2;
        s1 = 21'(x[15:0]) + 21'(x[31:16]) * 21'd15;
        s2 = 17'(s1[15:0]) + 17'(s1[20:16]) * 17'd15;
        if (s2 >= 17'(ADL_MOD)) s2 = s2 - 17'(ADL_MOD);
        return s2[15:0];
    endfunction

endpackage

// File: rtl/adl_lane.sv
// One lane of the checksum engine: a private pair of running sums.
// Each enabled cycle adds the lane's byte into A, then the new A into B,
// both modulo 65521. Assumes clr and en are never needed in the same cycle
// for different messages (clr wins).
module adl_lane
    import adl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    input  logic [7:0] byte_i,
    output sum16_t     a_o,
    output sum16_t     b_o
);

    sum16_t a_q, b_q;
    sum16_t a_nx, b_nx;

    // Next sums for one byte step.
    always_comb begin
        a_nx = mod_add(a_q, {8'h00, byte_i});
        b_nx = mod_add(b_q, a_nx);
    end

    // Sum registers: cleared on reset or at the end of a message.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            a_q <= '0;
            b_q <= '0;
        end else if (en) begin
            a_q <= a_nx;
            b_q <= b_nx;
        end
    end

    assign a_o = a_q;
    assign b_o = b_q;

endmodule

// File: rtl/adl_merge.sv
// Merge sequencer: after the last beat it visits lane k = 0..LANES-1, one per
// cycle, accumulating A = 1 + sum(A_k) and
// B = len + sum(LANES*B_k - k*A_k), all modulo 65521. Subtraction is done by
// adding the modular complement. done_o pulses the cycle after lane LANES-1.
// Assumes lane sums are held stable while busy_o is high.
module adl_merge
    import adl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  sum16_t                  len_i,
    input  logic [LANES-1:0][15:0]  a_all,
    input  logic [LANES-1:0][15:0]  b_all,
    output logic                    busy_o,
    output logic                    last_step_o,
    output logic                    done_o,
    output logic [31:0]             cks_o
);

    localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [IW-1:0] idx_q;
    sum16_t        acc_a, acc_b;
    logic          busy_q, done_q;
    sum16_t        a_k, b_k, nxt_a, nxt_b, wb, wa, neg_wa;

    // One merge step for the currently selected lane.
    always_comb begin
        a_k    = a_all[idx_q];
        b_k    = b_all[idx_q];
        nxt_a  = mod_add(acc_a, a_k);
        wb     = fold32(32'(b_k) * 32'(LANES));
        wa     = fold32(32'(a_k) * 32'(idx_q));
        neg_wa = (wa == '0) ? '0 : sum16_t'(16'(ADL_MOD) - wa);
        nxt_b  = fold32(32'(acc_b) + 32'(wb) + 32'(neg_wa));
    end

    assign last_step_o = busy_q && (idx_q == IW'(LANES - 1));

    // Sequencer state, lane index and accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
            acc_a  <= '0;
            acc_b  <= '0;
        end else begin
            done_q <= last_step_o;
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                acc_a  <= 16'd1;
                acc_b  <= len_i;
            end else if (busy_q) begin
                acc_a <= nxt_a;
                acc_b <= nxt_b;
                if (last_step_o) begin
                    busy_q <= 1'b0;
                    idx_q  <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign cks_o  = {acc_b, acc_a};

endmodule

// File: rtl/adl_engine.sv
// Top of the multi-lane Adler-32 engine. Accepts LANES bytes per beat,
// masks lanes below the beat's byte count to zero (front padding), feeds the
// lanes, keeps the true length modulo 65521, and starts the merge on the
// last beat. Assumes only the first beat of a message is partial and
// in_count <= LANES.
module adl_engine
    import adl_pkg::*;
#(
    parameter int LANES = 4,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [8*LANES-1:0]   in_data,
    input  logic [CW-1:0]        in_count,
    input  logic                 in_last,
    output logic                 done_o,
    output logic [31:0]          cks_o
);

    logic                   accept, busy, last_step;
    logic [LANES-1:0][15:0] lane_a, lane_b;
    sum16_t                 len_q, len_nx;

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    // Per-lane byte masking and accumulation.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] byte_m;
        assign byte_m = (32'(in_count) + 32'(l) >= 32'(LANES)) ?
                        in_data[8*l +: 8] : 8'h00;
        adl_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (accept),
            .clr    (last_step),
            .byte_i (byte_m),
            .a_o    (lane_a[l]),
            .b_o    (lane_b[l])
        );
    end

    // True message length, kept reduced.
    assign len_nx = mod_add(len_q, 16'(in_count));

    // Length register: grows per accepted beat, cleared after the merge.
    always_ff @(posedge clk) begin
        if (!rst_n || last_step) len_q <= '0;
        else if (accept)         len_q <= len_nx;
    end

    adl_merge #(.LANES(LANES)) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept && in_last),
        .len_i       (len_nx),
        .a_all       (lane_a),
        .b_all       (lane_b),
        .busy_o      (busy),
        .last_step_o (last_step),
        .done_o      (done_o),
        .cks_o       (cks_o)
    );

endmodule

// File: rtl/adl_engine_chk.sv
// Checker for adl_engine: result range, lane register range and the
// handshake/strobe timing of the merge. Bound to the top below.
module adl_engine_chk #(
    parameter int LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   in_last,
    input logic                   done_o,
    input logic [31:0]            cks_o,
    input logic [LANES-1:0][15:0] lane_a,
    input logic [LANES-1:0][15:0] lane_b
);

    logic [15:0] stall_cnt;

    // Counts consecutive cycles with in_ready low.
    always_ff @(posedge clk) begin
        if (!rst_n || in_ready) stall_cnt <= '0;
        else                    stall_cnt <= stall_cnt + 16'd1;
    end

    // R1
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cks_o[15:0] < 16'd65521 && cks_o[31:16] < 16'd65521));

    for (genvar l = 0; l < LANES; l++) begin : g_lchk
        // R2
        lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_a[l] < 16'd65521 && lane_b[l] < 16'd65521);
    end

    // R7
    stall_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> in_ready);

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (stall_cnt == 16'(LANES)));

endmodule

bind adl_engine adl_engine_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .done_o   (done_o),
    .cks_o    (cks_o),
    .lane_a   (lane_a),
    .lane_b   (lane_b)
);

// File: tb/tb_adl_engine.sv
// Bench for adl_engine with LANES = 4: length sweep, several byte patterns,
// idle gaps, long wrapping messages; reference is a serial checksum.
module tb_adl_engine;

    localparam int N  = 4;
    localparam int CW = $clog2(N + 1);
    localparam int M  = 65521;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [8*N-1:0] in_data = '0;
    logic [CW-1:0]  in_count = '0;
    logic           in_last = 1'b0;
    logic           done_o;
    logic [31:0]    cks_o;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    logic [7:0] msg [0:1023];

    always #5 clk = ~clk;

    adl_engine #(.LANES(N)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_count(in_count), .in_last(in_last),
        .done_o(done_o), .cks_o(cks_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int pat, input int i, input int len);
        case (pat)
            0:       return 8'hFF;
            1:       return 8'((i * 37 + len * 11 + 3) & 255);
            2:       return (i == len - 1) ? 8'hFF : 8'h00;
            default: return 8'(((i * i) ^ (i >> 3)) & 255);
        endcase
    endfunction

    task automatic run_msg(input int len, input int pat, input bit gaps,
                           input string tag);
        int a = 1;
        int b = 0;
        int pad = (N - (len % N)) % N;
        int beats = (len == 0) ? 1 : (len + pad) / N;
        for (int i = 0; i < len; i++) begin
            msg[i] = gen(pat, i, len);
            a = (a + int'(msg[i])) % M;
            b = (b + a) % M;
        end
        for (int g = 0; g < beats; g++) begin
            @(negedge clk);
            if (gaps && (g % 2 == 1)) begin
                in_valid = 1'b0;
                in_data  = {N{8'h3C}};
                in_last  = 1'b1;
                @(negedge clk);
            end
            for (int l = 0; l < N; l++) begin
                int ti = g * N + l - pad;
                in_data[8*l +: 8] = (len == 0 || ti < 0) ? 8'hA5 : msg[ti];
            end
            in_count = (g == 0) ? CW'((len == 0) ? 0 : N - pad) : CW'(N);
            in_last  = (g == beats - 1);
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        for (int k = 1; k <= N + 1; k++) begin
            @(negedge clk);
            if (k == 1) in_valid = 1'b0;
            if (k <= N) begin
                chk("R7", "ready during merge", 32'(in_ready), 32'd0);
                chk("R7", "done early", 32'(done_o), 32'd0);
            end else begin
                chk("R7", "done strobe", 32'(done_o), 32'd1);
                chk("R7", "ready at done", 32'(in_ready), 32'd1);
                chk("R4", "A half", {16'h0, cks_o[15:0]}, 32'(a));
                chk("R5", "B half", {16'h0, cks_o[31:16]}, 32'(b));
                chk("R1", "halves in range",
                    32'(cks_o[15:0] < 16'(M) && cks_o[31:16] < 16'(M)), 32'd1);
                chk(tag, $sformatf("checksum len=%0d pat=%0d", len, pat),
                    cks_o, {16'(b), 16'(a)});
            end
        end
        @(negedge clk);
        chk("R7", "done one cycle", 32'(done_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "reset ready", 32'(in_ready), 32'd1);
        chk("R7", "reset done", 32'(done_o), 32'd0);
        chk("R6", "reset result", cks_o, 32'd0);
        // R8: empty message
        run_msg(0, 1, 1'b0, "R8");
        // R3 / R9 / R10: length sweep over all front-padding amounts
        for (int len = 1; len <= 40; len++) begin
            run_msg(len, 1, len[0], (len % N != 0) ? "R3" : "R9");
            run_msg(len, 3, !len[0], "R10");
            run_msg(len, 2, 1'b0, "R6");
        end
        run_msg(0, 0, 1'b0, "R8");
        // R2: long runs of 0xFF force many wraps
        run_msg(700, 0, 1'b0, "R2");
        run_msg(1023, 3, 1'b1, "R10");
        run_msg(1024, 1, 1'b0, "R9");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog expired: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule